// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Fault Output Stage

This block sits between a PWM generator and an external gate driver. It turns each of four raw PWM bits into a complementary pair of drive signals, one for the high-side switch and one for the low-side switch of a half bridge. Each channel has its own controller. On every edge of its raw bit, the controller holds both switches off for a programmable number of clock cycles. Only then does it turn on the side that matches the new raw level. This prevents both switches of a leg from conducting at once (shoot-through).

A separate fault monitor watches an active-low fault line from the gate driver. The raw fault level forces every output low through gates alone, with no register in the path. A synchronized copy of the fault line sets a sticky latch, and the latch keeps the outputs off after the line recovers. Software releases the latch with a one-cycle clear strobe, and the strobe only takes effect once the fault line is high again. A per-channel enable mask can turn off any leg on its own.

Top module: `bridge_drive_guard`

## Requirements
- R1: On any channel, the high-side and low-side outputs are never high at the same time.
- R2: When a channel's raw bit differs from its last tracked level at a clock edge, both of its outputs are low for exactly D clock cycles. D is the value of `dead_cnt` at that edge. After that, `hs_out` is high if the raw level is 1, and `ls_out` is high if it is 0. The outputs follow the raw bit one clock later.
- R3: When `dead_cnt` is 0, a raw edge switches the outputs to the matching side at the next clock edge, with no cycle in which both are low.
- R4: A raw edge that arrives during blanking reloads the blanking count from `dead_cnt`. The side enabled afterwards follows the latest raw level.
- R5: The channels run independently. An edge on one channel leaves the outputs of the other channels unchanged.
- R6: While `fault_n` is 0, every output is 0 at once, without waiting for a clock edge.
- R7: `fault_n` held low for three or more clock cycles sets `fault_latched`. A set latch stays set while `fault_clr` is 0 and holds every output at 0, even after `fault_n` returns high.
- R8: The latch clears on a clock edge only when `fault_clr` is 1 and the synchronized `fault_n` is high. The synchronized level follows the pin two cycles later. A strobe while `fault_n` is low is ignored.
- R9: When bit i of `chan_en` is 0, both outputs of channel i are 0. The other channels are unaffected.
- R10: After reset, `fault_latched` is 0, every tracked raw level is 0, and every channel has its low side on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_pwm | input | 4 | Raw PWM level per channel |
| dead_cnt | input | 8 | Blanking length in clock cycles; 0 means none |
| chan_en | input | 4 | Per-channel output enable, bit i for channel i |
| fault_n | input | 1 | Active-low fault line from the gate driver |
| fault_clr | input | 1 | One-cycle strobe that releases the fault latch |
| hs_out | output | 4 | High-side drive per channel |
| ls_out | output | 4 | Low-side drive per channel |
| fault_latched | output | 1 | State of the sticky fault latch |

## Verification
A wrong channel state shows up at the ports in the first cycle after the raw edge. It appears as a blanking window of the wrong length, as the wrong side coming on, or as both sides high together. The bench counts the low cycles of every window for a sweep of dead-time values on all channels and in both directions, so an off-by-one shows in the count. A fault latch that sets, holds or clears wrongly shows within a few cycles, both on `fault_latched` and as outputs that come back too early or stay off too long. The fault-to-output path is checked before any clock edge has passed.

// File: rtl/bdg_pkg.sv
`timescale 1ns/1ps
package bdg_pkg;
  typedef enum logic [1:0] {
    DT_LOW   = 2'b00,
    DT_HIGH  = 2'b01,
    DT_BLANK = 2'b10
  } dt_state_e;
endpackage

// File: rtl/bdg_deadtime.sv
`timescale 1ns/1ps
module bdg_deadtime #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           raw,
  input  logic [DTW-1:0] dead_cnt,
  output logic           drv_h,
  output logic           drv_l
);
  import bdg_pkg::*;

  localparam logic [DTW-1:0] ONE = DTW'(1);

  dt_state_e      st_q, st_d;
  logic           lvl_q, lvl_d;
  logic [DTW-1:0] cnt_q, cnt_d;
  logic           cnt_en;
  logic           edge_seen;
  logic           no_blank;

  assign edge_seen = raw ^ lvl_q;
  assign no_blank  = (dead_cnt == '0);

  // next-state logic
  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (edge_seen) begin
      lvl_d = raw;
      if (no_blank) begin
        st_d = raw ? DT_HIGH : DT_LOW;
      end else begin
        st_d   = DT_BLANK;
        cnt_d  = dead_cnt;
        cnt_en = 1'b1;
      end
    end else if (st_q == DT_BLANK) begin
      if (cnt_q <= ONE) begin
        st_d = lvl_q ? DT_HIGH : DT_LOW;
      end else begin
        cnt_d  = cnt_q - ONE;
        cnt_en = 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DT_LOW;
      lvl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign drv_h = (st_q == DT_HIGH);
  assign drv_l = (st_q == DT_LOW);
endmodule

// File: rtl/bdg_sync.sv
`timescale 1ns/1ps
module bdg_sync #(
  parameter int   STAGES   = 2,
  parameter logic RST_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= {STAGES{RST_LVL}};
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/bdg_fault_latch.sv
`timescale 1ns/1ps
module bdg_fault_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n,
  input  logic clr,
  output logic latched
);
  logic fn_sync;
  logic lat_q, lat_d;
  logic lat_en;

  bdg_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (fault_n),
    .q     (fn_sync)
  );

  // set while the synchronized line is low; clear needs a high line and the strobe
  always_comb begin
    lat_d  = lat_q;
    lat_en = 1'b0;
    if (!fn_sync) begin
      lat_d  = 1'b1;
      lat_en = 1'b1;
    end else if (clr) begin
      lat_d  = 1'b0;
      lat_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end

  assign latched = lat_q;
endmodule

// File: rtl/bridge_drive_guard.sv
`timescale 1ns/1ps
module bridge_drive_guard #(
  parameter int NCH         = 4,
  parameter int DTW         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] raw_pwm,
  input  logic [DTW-1:0] dead_cnt,
  input  logic [NCH-1:0] chan_en,
  input  logic           fault_n,
  input  logic           fault_clr,
  output logic [NCH-1:0] hs_out,
  output logic [NCH-1:0] ls_out,
  output logic           fault_latched
);
  logic [NCH-1:0] fsm_h;
  logic [NCH-1:0] fsm_l;
  logic           latch_q;
  logic           shutdown;

  for (genvar i = 0; i < NCH; i++) begin : g_leg
    bdg_deadtime #(.DTW(DTW)) u_dt (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (raw_pwm[i]),
      .dead_cnt (dead_cnt),
      .drv_h    (fsm_h[i]),
      .drv_l    (fsm_l[i])
    );
  end

  bdg_fault_latch #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault_n (fault_n),
    .clr     (fault_clr),
    .latched (latch_q)
  );

  // raw pin blanks without a clock; latch keeps it blanked afterwards
  assign shutdown      = ~fault_n | latch_q;
  assign hs_out        = chan_en & ~{NCH{shutdown}} & fsm_h;
  assign ls_out        = chan_en & ~{NCH{shutdown}} & fsm_l;
  assign fault_latched = latch_q;
endmodule

// File: rtl/bdg_checker.sv
`timescale 1ns/1ps
module bdg_checker #(
  parameter int NCH = 4,
  parameter int DTW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] raw_pwm,
  input logic [DTW-1:0] dead_cnt,
  input logic [NCH-1:0] chan_en,
  input logic           fault_n,
  input logic           fault_clr,
  input logic [NCH-1:0] hs_out,
  input logic [NCH-1:0] ls_out,
  input logic           fault_latched
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_never_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_out[i] && ls_out[i]));

    p_edge_blanks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && (raw_pwm[i] != $past(raw_pwm[i])) && (dead_cnt != '0))
      |=> (!hs_out[i] && !ls_out[i]));

    p_disabled_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[i] |-> (!hs_out[i] && !ls_out[i]));
  end

  p_fault_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (hs_out == '0 && ls_out == '0));

  p_latch_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> (hs_out == '0 && ls_out == '0));

  p_latch_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !fault_clr) |=> fault_latched);

  p_clear_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_latched) |-> $past(fault_clr));
endmodule

bind bridge_drive_guard bdg_checker #(.NCH(NCH), .DTW(DTW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .raw_pwm       (raw_pwm),
  .dead_cnt      (dead_cnt),
  .chan_en       (chan_en),
  .fault_n       (fault_n),
  .fault_clr     (fault_clr),
  .hs_out        (hs_out),
  .ls_out        (ls_out),
  .fault_latched (fault_latched)
);

// File: tb/bridge_drive_guard_tb.sv
`timescale 1ns/1ps
module bridge_drive_guard_tb;
  localparam int NCH = 4;
  localparam int DTW = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] raw_pwm;
  logic [DTW-1:0] dead_cnt;
  logic [NCH-1:0] chan_en;
  logic           fault_n;
  logic           fault_clr;
  logic [NCH-1:0] hs_out;
  logic [NCH-1:0] ls_out;
  logic           fault_latched;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bridge_drive_guard #(.NCH(NCH), .DTW(DTW)) u_dut (
    .clk(clk), .rst_n(rst_n), .raw_pwm(raw_pwm), .dead_cnt(dead_cnt),
    .chan_en(chan_en), .fault_n(fault_n), .fault_clr(fault_clr),
    .hs_out(hs_out), .ls_out(ls_out), .fault_latched(fault_latched)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // Drive a new level on one channel at a negedge and count the low samples
  // that follow; optionally flip back after flip_at samples (0 = never).
  task automatic blank_run(input int ch, input bit lvl, input int flip_at,
                           output int lows, output int both);
    raw_pwm[ch] = lvl;
    lows = 0;
    both = 0;
    for (int s = 1; s < 400; s++) begin
      @(negedge clk);
      if (hs_out[ch] && ls_out[ch]) both++;
      if (hs_out[ch] || ls_out[ch]) break;
      lows++;
      if (s == flip_at) raw_pwm[ch] = ~raw_pwm[ch];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int dvals[7] = '{0, 1, 2, 3, 4, 7, 13};
    int lows, both;
    rst_n     = 1'b0;
    raw_pwm   = '0;
    dead_cnt  = '0;
    chan_en   = '1;
    fault_n   = 1'b1;
    fault_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 ls_out", ls_out, 4'hF);
    check("R10 hs_out", hs_out, 0);
    check("R10 latch", fault_latched, 0);

    // R2/R3/R5/R1: blanking sweep on every channel, both directions
    foreach (dvals[k]) begin
      dead_cnt = DTW'(dvals[k]);
      for (int ch = 0; ch < NCH; ch++) begin
        blank_run(ch, 1'b1, 0, lows, both);
        check(dvals[k] == 0 ? "R3 rise lows" : "R2 rise lows", lows, dvals[k]);
        check("R2 rise side", {hs_out[ch], ls_out[ch]}, 2'b10);
        check("R1 rise both", both, 0);
        check("R5 others", {hs_out & ~(4'b1 << ch), ls_out & ~(4'b1 << ch)},
              {4'h0, 4'hF & ~(4'b1 << ch)});
        blank_run(ch, 1'b0, 0, lows, both);
        check(dvals[k] == 0 ? "R3 fall lows" : "R2 fall lows", lows, dvals[k]);
        check("R2 fall side", {hs_out[ch], ls_out[ch]}, 2'b01);
        check("R1 fall both", both, 0);
      end
    end

    // R4: edge during blanking reloads the count
    dead_cnt = 8'd6;
    blank_run(2, 1'b1, 3, lows, both);
    check("R4 restart lows", lows, 9);
    check("R4 restart side", {hs_out[2], ls_out[2]}, 2'b01);
    blank_run(1, 1'b1, 1, lows, both);
    check("R4 early restart lows", lows, 7);
    check("R4 early restart side", {hs_out[1], ls_out[1]}, 2'b01);

    // R5: channel 0 high stays high while channel 3 blanks
    dead_cnt = 8'd4;
    blank_run(0, 1'b1, 0, lows, both);
    blank_run(3, 1'b1, 0, lows, both);
    check("R5 ch0 held", {hs_out[0], ls_out[0]}, 2'b10);
    check("R5 ch3 lows", lows, 4);

    // R9: enable mask per channel, raw = 1001
    for (int ch = 0; ch < NCH; ch++) begin
      chan_en = ~(4'b1 << ch);
      @(negedge clk);
      check("R9 hs", hs_out, 4'b1001 & chan_en);
      check("R9 ls", ls_out, 4'b0110 & chan_en);
    end
    chan_en = '1;
    @(negedge clk);

    // R6: combinational blanking
    fault_n = 1'b0;
    #1;
    check("R6 immediate hs", hs_out, 0);
    check("R6 immediate ls", ls_out, 0);
    repeat (5) @(negedge clk);
    check("R7 latch set", fault_latched, 1);
    fault_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 hold latch", fault_latched, 1);
    check("R7 hold outputs", {hs_out, ls_out}, 0);

    // R8: strobe while line low is ignored
    fault_n = 1'b0;
    repeat (5) @(negedge clk);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    check("R8 ignored clear", fault_latched, 1);
    fault_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 still set", fault_latched, 1);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    check("R8 cleared", fault_latched, 0);
    check("R8 hs restored", hs_out, 4'b1001);
    check("R8 ls restored", ls_out, 4'b0110);

    done = 1'b1;
    summary();
  end
endmodule